// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sits in a fetch path and cuts a window of eight 16-bit halfwords into whole instructions of one, two, four or eight halfwords. A two-bit size tag in the low bits of an instruction's first halfword gives its length. Every later halfword of the same instruction must carry a fixed continuation tag. A wrong continuation tag does not stop decoding: the record is still emitted, and it carries an error flag.

Each cycle the fetch side presents the window together with a count of valid halfwords, which always start at halfword 0. One cycle later the block returns up to two instruction records. Each record holds the size tag, the halfword offset and an opcode field whose width grows with the size class. The block also returns the number of halfwords it used. When an instruction has started inside the valid part of the window but does not fit in it, the block raises a stall. That slot and any slot after it are left empty, so the fetch side can shift the window by the consumed count and present the rest again with more halfwords.

Top module: `vlen_decoder`

## Requirements
- R1: The size tag is bits [1:0] of an instruction's first halfword. Tag 00 means 1 halfword, 01 means 2, 10 means 4 and 11 means 8. An emitted record reports its tag on its size field.
- R2: The first record always starts at halfword 0. The second record starts at the halfword just after the end of the first. Offsets are reported in halfwords.
- R3: At most two records are emitted per cycle. The second is emitted only if the first was. The size, offset, opcode and error fields of an empty slot read zero.
- R4: The consumed count equals the total length, in halfwords, of the records emitted in that cycle.
- R5: If an instruction's first halfword lies inside the valid count but its full length goes past the count, the stall output is high. That slot and every later slot are empty, and earlier slots are still emitted.
- R6: There is no stall when the valid count is zero, or when the emitted records use up exactly the valid halfwords.
- R7: For a 1-halfword instruction, the opcode is bits [6:2] of its halfword, zero-extended to 20 bits.
- R8: For a 2-halfword instruction, the opcode is bits [11:2] of its first halfword, zero-extended to 20 bits.
- R9: For 4- and 8-halfword instructions, the opcode is 20 bits wide. Bits [13:0] are the first halfword's bits [15:2], and bits [19:14] are the second halfword's bits [7:2].
- R10: Every later halfword of an instruction must have 10 in bits [1:0]. If any does not, the record's error bit is set. The record is still emitted and still counted as consumed.
- R11: All outputs are registered and reflect the window presented on the previous clock edge. While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winData | input | 128 | Fetch window; halfword i is bits [16*i+15:16*i] |
| winCount | input | 4 | Number of valid halfwords, 0 to 8 |
| outValid | output | 2 | Record emitted, one bit per slot |
| outSize | output | 4 | Size tag, 2 bits per slot (slot 0 in bits [1:0]) |
| outOffset | output | 6 | Start halfword, 3 bits per slot |
| outOpcode | output | 40 | Opcode field, 20 bits per slot |
| outError | output | 2 | Continuation tag error, one bit per slot |
| outConsumed | output | 4 | Halfwords used this cycle |
| outStall | output | 1 | A started instruction does not fit in the window |

## Verification
Two functions can fall in the same cycle: emitting the first record, and stalling on the second. They meet when the count covers the first instruction but ends partway through the second. The bench builds such windows on purpose, for example a 2-halfword instruction followed by a 4-halfword one with only four halfwords valid. A correct result is a valid first slot, an empty second slot, stall high and a consumed count of two. A continuation error can also ride on the record emitted alongside that stall. Both the directed and the generated windows are judged against a model built from the requirements.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  localparam int HW_W     = 16;
  localparam int WIN_HW   = 8;
  localparam int SLOTS    = 2;
  localparam int TAG_W    = 2;
  localparam int OP_W     = 20;
  localparam int OP16_W   = 5;
  localparam int OP32_W   = 10;
  localparam logic [TAG_W-1:0] CONT_TAG = 2'b10;

  localparam int WIN_BITS = HW_W * WIN_HW;
  localparam int OFF_W    = $clog2(WIN_HW);
  localparam int CNT_W    = $clog2(WIN_HW + 1);
  localparam int SUM_W    = $clog2(WIN_HW * SLOTS + 1);
  localparam int LOW_W    = HW_W - TAG_W;
  localparam int HIGH_W   = OP_W - LOW_W;

  typedef struct packed {
    logic [SLOTS-1:0]            emit;
    logic [SLOTS-1:0][OFF_W-1:0] start;
    logic [SLOTS-1:0][TAG_W-1:0] size;
    logic [SLOTS-1:0]            bad;
    logic                        stall;
    logic [CNT_W-1:0]            used;
  } lenCtl_t;

  function automatic logic [HW_W-1:0] hwAt(input logic [WIN_BITS-1:0] w,
                                           input logic [SUM_W-1:0] idx);
    logic [HW_W-1:0] r;
    r = '0;
    for (int i = 0; i < WIN_HW; i++) begin
      if (idx == SUM_W'(i)) r = w[i*HW_W +: HW_W];
    end
    return r;
  endfunction

  function automatic logic [SUM_W-1:0] tagSpan(input logic [TAG_W-1:0] tag);
    return SUM_W'(1) << tag;
  endfunction
endpackage

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
(
  input  logic [WIN_BITS-1:0] winData,
  input  logic [CNT_W-1:0]    winCount,
  output lenCtl_t             ctl
);
  always_comb begin
    logic [SUM_W-1:0] avail;
    logic [SUM_W-1:0] pos;
    logic [SUM_W-1:0] span;
    logic [HW_W-1:0]  head;
    logic [HW_W-1:0]  tail;
    logic [TAG_W-1:0] tag;
    logic             alive;
    logic             inRange;
    logic             fits;
    logic             bad;

    avail   = (winCount > CNT_W'(WIN_HW)) ? SUM_W'(WIN_HW) : SUM_W'(winCount);
    ctl     = '0;
    pos     = '0;
    alive   = 1'b1;
    head    = '0;
    tail    = '0;
    tag     = '0;
    span    = '0;
    inRange = 1'b0;
    fits    = 1'b0;
    bad     = 1'b0;

    for (int s = 0; s < SLOTS; s++) begin
      head    = hwAt(winData, pos);
      tag     = head[TAG_W-1:0];
      span    = tagSpan(tag);
      inRange = alive && (pos < avail);
      fits    = (pos + span) <= avail;
      bad     = 1'b0;
      if (inRange && fits) begin
        for (int k = 1; k < WIN_HW; k++) begin
          tail = hwAt(winData, pos + SUM_W'(k));
          if ((SUM_W'(k) < span) && (tail[TAG_W-1:0] != CONT_TAG)) bad = 1'b1;
        end
        ctl.emit[s]  = 1'b1;
        ctl.start[s] = pos[OFF_W-1:0];
        ctl.size[s]  = tag;
        ctl.bad[s]   = bad;
        pos          = pos + span;
      end else begin
        if (inRange) ctl.stall = 1'b1;
        alive = 1'b0;
      end
    end
    ctl.used = pos[CNT_W-1:0];
  end
endmodule

// File: rtl/vlen_dpath.sv
module vlen_dpath
  import vlen_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIN_BITS-1:0]      winData,
  input  lenCtl_t                  ctl,
  output logic [SLOTS-1:0]         validQ,
  output logic [SLOTS*TAG_W-1:0]   sizeQ,
  output logic [SLOTS*OFF_W-1:0]   offsetQ,
  output logic [SLOTS*OP_W-1:0]    opcodeQ,
  output logic [SLOTS-1:0]         errorQ,
  output logic [CNT_W-1:0]         usedQ,
  output logic                     stallQ
);
  logic [SLOTS-1:0][OP_W-1:0] opcNext;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [HW_W-1:0] firstHw;
    logic [HW_W-1:0] secondHw;
    logic [OP_W-1:0] opc;

    assign firstHw  = hwAt(winData, SUM_W'(ctl.start[s]));
    assign secondHw = hwAt(winData, SUM_W'(ctl.start[s]) + SUM_W'(1));

    always_comb begin
      case (ctl.size[s])
        2'b00:   opc = OP_W'(firstHw[TAG_W +: OP16_W]);
        2'b01:   opc = OP_W'(firstHw[TAG_W +: OP32_W]);
        default: opc = {secondHw[TAG_W +: HIGH_W], firstHw[HW_W-1:TAG_W]};
      endcase
    end

    assign opcNext[s] = opc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      sizeQ   <= '0;
      offsetQ <= '0;
      opcodeQ <= '0;
      errorQ  <= '0;
      usedQ   <= '0;
      stallQ  <= 1'b0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        validQ[s]                 <= ctl.emit[s];
        sizeQ[s*TAG_W +: TAG_W]   <= ctl.emit[s] ? ctl.size[s]  : '0;
        offsetQ[s*OFF_W +: OFF_W] <= ctl.emit[s] ? ctl.start[s] : '0;
        opcodeQ[s*OP_W +: OP_W]   <= ctl.emit[s] ? opcNext[s]   : '0;
        errorQ[s]                 <= ctl.emit[s] & ctl.bad[s];
      end
      usedQ  <= ctl.used;
      stallQ <= ctl.stall;
    end
  end
endmodule

// File: rtl/vlen_decoder.sv
module vlen_decoder
  import vlen_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIN_BITS-1:0]    winData,
  input  logic [CNT_W-1:0]       winCount,
  output logic [SLOTS-1:0]       outValid,
  output logic [SLOTS*TAG_W-1:0] outSize,
  output logic [SLOTS*OFF_W-1:0] outOffset,
  output logic [SLOTS*OP_W-1:0]  outOpcode,
  output logic [SLOTS-1:0]       outError,
  output logic [CNT_W-1:0]       outConsumed,
  output logic                   outStall
);
  lenCtl_t ctl;

  vlen_ctrl ctrl_i (
    .winData (winData),
    .winCount(winCount),
    .ctl     (ctl)
  );

  vlen_dpath dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .winData(winData),
    .ctl    (ctl),
    .validQ (outValid),
    .sizeQ  (outSize),
    .offsetQ(outOffset),
    .opcodeQ(outOpcode),
    .errorQ (outError),
    .usedQ  (outConsumed),
    .stallQ (outStall)
  );
endmodule

// File: rtl/vlen_checker.sv
module vlen_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] winCount,
  input logic [1:0] outValid,
  input logic [3:0] outSize,
  input logic [5:0] outOffset,
  input logic [1:0] outError,
  input logic [3:0] outConsumed,
  input logic       outStall
);
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    outValid[1] |-> outValid[0]); // R3

  AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid[1] |-> (outOffset[5:3] == 3'd0 && outSize[3:2] == 2'd0 && !outError[1])); // R3

  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    outStall |-> (outValid != 2'b11)); // R5

  AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid[0] |-> (outOffset[2:0] == 3'd0)); // R2

  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid[1] |-> ({1'b0, outOffset[5:3]} == (4'd1 << outSize[1:0]))); // R2

  AST_USED_SUM: assert property (@(posedge clk) disable iff (!rstN)
    outConsumed == ((outValid[0] ? (4'd1 << outSize[1:0]) : 4'd0) +
                    (outValid[1] ? (4'd1 << outSize[3:2]) : 4'd0))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(winCount) == 4'd0) |-> (!outStall && outValid == 2'b00)); // R6
endmodule

bind vlen_decoder vlen_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .winCount   (winCount),
  .outValid   (outValid),
  .outSize    (outSize),
  .outOffset  (outOffset),
  .outError   (outError),
  .outConsumed(outConsumed),
  .outStall   (outStall)
);

// File: tb/vlen_decoder_tb_top.sv
module vlen_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] winData = '0;
  logic [3:0]   winCount = '0;
  logic [1:0]   outValid;
  logic [3:0]   outSize;
  logic [5:0]   outOffset;
  logic [39:0]  outOpcode;
  logic [1:0]   outError;
  logic [3:0]   outConsumed;
  logic         outStall;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [1:0]  v;
    logic [3:0]  sz;
    logic [5:0]  off;
    logic [39:0] op;
    logic [1:0]  err;
    logic [3:0]  used;
    logic        stall;
    int          cnt;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_decoder dut_i (
    .clk(clk), .rstN(rstN), .winData(winData), .winCount(winCount),
    .outValid(outValid), .outSize(outSize), .outOffset(outOffset),
    .outOpcode(outOpcode), .outError(outError), .outConsumed(outConsumed),
    .outStall(outStall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkHw(input logic [1:0] tag, input logic [13:0] pay);
    return {pay, tag};
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [15:0] h[8], input int cnt);
    exp_t e;
    int pos;
    bit go;
    e = '{v:'0, sz:'0, off:'0, op:'0, err:'0, used:'0, stall:1'b0, cnt:cnt};
    pos = 0;
    go = 1;
    for (int s = 0; s < 2; s++) begin
      if (go && pos < cnt) begin
        logic [1:0] t;
        int n;
        logic [19:0] o;
        t = h[pos][1:0];
        n = (t == 2'b00) ? 1 : (t == 2'b01) ? 2 : (t == 2'b10) ? 4 : 8;
        if (pos + n > cnt) begin
          e.stall = 1'b1;
          go = 0;
        end else begin
          if (t == 2'b00)      o = {15'd0, h[pos][6:2]};
          else if (t == 2'b01) o = {10'd0, h[pos][11:2]};
          else                 o = {h[pos+1][7:2], h[pos][15:2]};
          e.v[s] = 1'b1;
          e.sz[s*2 +: 2] = t;
          e.off[s*3 +: 3] = 3'(pos);
          e.op[s*20 +: 20] = o;
          for (int k = 1; k < n; k++)
            if (h[pos+k][1:0] != 2'b10) e.err[s] = 1'b1;
          pos += n;
        end
      end else begin
        go = 0;
      end
    end
    e.used = 4'(pos);
    return e;
  endfunction

  // Driver: present a window at the falling edge and queue its expectation
  task automatic apply(input logic [15:0] h[8], input int cnt);
    @(negedge clk);
    for (int i = 0; i < 8; i++) winData[i*16 +: 16] = h[i];
    winCount = 4'(cnt);
    sb.push_back(model(h, cnt));
  endtask

  // Monitor: compare one cycle after each queued window
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        string stallReq;
        e = sb.pop_front();
        stallReq = (e.cnt == 0 || int'(e.used) == e.cnt) ? "R6" : "R5";
        check(outValid == e.v, "R3", "valid", 40'(outValid), 40'(e.v));
        check(outStall == e.stall, stallReq, "stall", 40'(outStall), 40'(e.stall));
        check(outConsumed == e.used, "R4", "consumed", 40'(outConsumed), 40'(e.used));
        check(outSize == e.sz, "R1", "size", 40'(outSize), 40'(e.sz));
        check(outOffset == e.off, "R2", "offset", 40'(outOffset), 40'(e.off));
        check(outError == e.err, "R10", "error", 40'(outError), 40'(e.err));
        for (int s = 0; s < 2; s++) begin
          string r;
          r = (e.sz[s*2 +: 2] == 2'b00) ? "R7" : (e.sz[s*2 +: 2] == 2'b01) ? "R8" : "R9";
          check(outOpcode[s*20 +: 20] == e.op[s*20 +: 20], r, "opcode",
                40'(outOpcode[s*20 +: 20]), 40'(e.op[s*20 +: 20]));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] h[8];

    // R11: reset state
    repeat (3) @(negedge clk);
    winData = {8{16'hFFFF}};
    winCount = 4'd8;
    @(negedge clk);
    check(outValid == 2'b00 && outStall == 1'b0 && outConsumed == 4'd0 &&
          outOpcode == 40'd0 && outSize == 4'd0 && outOffset == 6'd0 && outError == 2'd0,
          "R11", "reset outputs", {outValid, outStall, outConsumed, outOpcode[33:0]}, 40'd0);
    winCount = 4'd0;
    rstN = 1'b1;

    // R1 R7: two short instructions, exact fit (R6)
    foreach (h[i]) h[i] = mkHw(2'b00, 14'(i * 7 + 3));
    h[0] = mkHw(2'b00, 14'h0055);
    h[1] = mkHw(2'b00, 14'h002A);
    apply(h, 2);
    // R8: two-halfword then one-halfword
    h[0] = mkHw(2'b01, 14'h2ABC); h[1] = mkHw(2'b10, 14'h1111); h[2] = mkHw(2'b00, 14'h001F);
    apply(h, 3);
    // R9: four-halfword then two-halfword, count exactly six
    h[0] = mkHw(2'b10, 14'h3FFE); h[1] = mkHw(2'b10, 14'h00FC);
    h[2] = mkHw(2'b10, 14'h0001); h[3] = mkHw(2'b10, 14'h0002);
    h[4] = mkHw(2'b01, 14'h0333); h[5] = mkHw(2'b10, 14'h0000);
    apply(h, 6);
    // R9: eight-halfword fills window, no second slot
    h[0] = mkHw(2'b11, 14'h1234);
    for (int i = 1; i < 8; i++) h[i] = mkHw(2'b10, 14'(i * 301));
    apply(h, 8);
    // R5: eight-halfword with only five valid
    apply(h, 5);
    // R5: first emitted, second stalls in same cycle
    h[0] = mkHw(2'b01, 14'h0A0A); h[1] = mkHw(2'b10, 14'h0000);
    h[2] = mkHw(2'b10, 14'h3C3C); h[3] = mkHw(2'b10, 14'h0505);
    apply(h, 4);
    // R10 with R5: bad continuation on the emitted record plus a stall
    h[1] = mkHw(2'b11, 14'h0000);
    apply(h, 4);
    // R6: idle window
    apply(h, 0);
    // R10: bad tag inside a four-halfword instruction
    h[0] = mkHw(2'b10, 14'h0F0F); h[1] = mkHw(2'b10, 14'h0077);
    h[2] = mkHw(2'b00, 14'h0000); h[3] = mkHw(2'b10, 14'h0000);
    h[4] = mkHw(2'b00, 14'h0011);
    apply(h, 5);
    // R3: two four-halfword instructions
    for (int i = 0; i < 8; i++) h[i] = mkHw(2'b10, 14'(i * 911));
    h[0] = mkHw(2'b10, 14'h2468); h[4] = mkHw(2'b10, 14'h1357);
    apply(h, 8);
    // R6: single short instruction with count one
    h[0] = mkHw(2'b00, 14'h007C);
    apply(h, 1);

    // Generated streams
    for (int it = 0; it < 300; it++) begin
      int p;
      p = 0;
      foreach (h[i]) h[i] = 16'($urandom);
      while (p < 8) begin
        int n;
        logic [1:0] t;
        t = 2'($urandom % 4);
        n = 1 << t;
        h[p] = mkHw(t, 14'($urandom));
        for (int k = 1; k < n; k++)
          if (p + k < 8)
            h[p+k] = mkHw(($urandom % 8 == 0) ? 2'($urandom) : 2'b10, 14'($urandom));
        p += n;
      end
      apply(h, int'($urandom % 9));
    end

    apply(h, 0);
    @(posedge clk);
    #2;
    @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule